// File: doc/BRIEF.md
# Timestamp-Ordered Cell Resequencing Multiplexor

This block sits at an output port behind several slower switching layers that work in parallel. Each layer hands over cells for this output on its own lane, and each cell carries the timestamp it was given on arrival at the switch input. Because the layers run independently, cells reach this block out of their original order. The block keeps them in a small buffer with a fixed bound and puts them back onto one full-rate output line. It sends at most one cell per output time slot, always the buffered cell with the earliest timestamp.

A cell can leave only after it has aged by a fixed release delay, measured against a local slot counter. That delay gives late cells from slower layers time to arrive before an earlier-stamped cell could be overtaken, and it also bounds the extra latency the block adds. Timestamps are compared modulo the timestamp width, so the counter may wrap freely as long as no buffered cell is older than half the timestamp range.

The buffer holds `NUM_PORTS * NUM_LAYERS` cells. When an arriving cell finds no free place, it is discarded and a one-slot error flag is raised.

Top module: `reseq_mux`

## Requirements
- R1: A synchronous, active-high `rst` empties the buffer and clears the slot counter, `out_valid` and `overflow`. After `rst` is released, `out_valid` stays low until newly accepted cells become eligible.
- R2: The slot counter is 0 on the first clock edge after reset and advances by one on every later edge. A buffered cell is eligible in a slot when (counter − timestamp) mod 2^TS_W ≥ RELEASE_DLY. A cell accepted at an edge is first considered in the following slot.
- R3: Among the eligible cells, the one with the largest age (the earliest timestamp) is chosen. Ties go to the lowest-numbered buffer place.
- R4: At most one cell leaves per slot. `out_valid` is low in every slot in which no buffered cell is eligible.
- R5: Ages are computed with modular subtraction, so ordering and eligibility are correct when the counter or the timestamps wrap through zero.
- R6: The buffer has DEPTH = NUM_PORTS*NUM_LAYERS places. Lanes are served in index order, lane 0 first, and each takes the lowest-numbered free place. A place that a departing cell frees becomes available only in the next slot.
- R7: `overflow` is high for exactly the slot after an edge at which some valid lane found no free place. That lane's cell is discarded and never emitted.
- R8: Outputs are registered. A selection made in a slot appears on `out_valid`, `out_cell` and `out_ts` after that slot's edge, carrying the chosen cell's payload and timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one output slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lane_valid | input | NUM_LAYERS | Per-lane cell present |
| lane_cell | input | NUM_LAYERS*CELL_W | Lane i payload at bits [i*CELL_W +: CELL_W] |
| lane_ts | input | NUM_LAYERS*TS_W | Lane i arrival timestamp at bits [i*TS_W +: TS_W] |
| out_valid | output | 1 | A cell is on the output line this slot |
| out_cell | output | CELL_W | Payload of the emitted cell |
| out_ts | output | TS_W | Timestamp of the emitted cell |
| overflow | output | 1 | A cell was dropped for lack of space in the previous slot |

## Verification
A lone cell stamped with the current slot shows whether release happens exactly at the delay boundary and not one slot early or late. Lanes given shuffled offsets in the same slot and in adjacent slots show whether the choice follows age rather than lane number or order of arrival. Bursts placed just before the counter passes zero expose a non-modular comparison. A full-rate burst on every lane separates correct capacity and drop handling from off-by-one depth errors or leaks of dropped cells. A long seeded random stream with mixed offsets, plus a reset issued while the buffer is occupied, covers tie-breaking and the reuse of freed places.

// File: rtl/reseq_pkg.sv
package reseq_pkg;

  // Width of an index into n places, never less than one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/reseq_slot_clock.sv
module reseq_slot_clock #(
  parameter int unsigned TS_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now_o
);

  // Free-running local slot counter; wraps modulo 2^TS_W.
  always_ff @(posedge clk) begin
    if (rst) now_o <= '0;
    else     now_o <= now_o + 1'b1;
  end

endmodule

// File: rtl/reseq_alloc.sv
module reseq_alloc #(
  parameter int unsigned LANES = 3,
  parameter int unsigned DEPTH = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic [LANES-1:0]       req,
  input  logic [DEPTH-1:0]       free_i,
  output logic [LANES-1:0]       grant,
  output logic [LANES*IDX_W-1:0] slot_o,
  output logic                   drop
);

  logic [DEPTH-1:0] avail;
  logic [IDX_W-1:0] sel;
  logic             hit;

  // Lanes claim places one after another, lowest index first.
  always_comb begin
    avail  = free_i;
    grant  = '0;
    slot_o = '0;
    drop   = 1'b0;
    sel    = '0;
    hit    = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      sel = '0;
      hit = 1'b0;
      for (int d = DEPTH - 1; d >= 0; d--) begin
        if (avail[d]) begin
          hit = 1'b1;
          sel = IDX_W'(d);
        end
      end
      if (req[l]) begin
        if (hit) begin
          grant[l]                   = 1'b1;
          slot_o[l*IDX_W +: IDX_W]   = sel;
          avail[sel]                 = 1'b0;
        end else begin
          drop = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/reseq_store.sv
module reseq_store #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned DEPTH  = 12,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CELL_W = 16,
  parameter int unsigned TS_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        wr_en,
  input  logic [LANES*IDX_W-1:0]  wr_slot,
  input  logic [LANES*CELL_W-1:0] wr_cell,
  input  logic [LANES*TS_W-1:0]   wr_ts,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_slot,
  output logic [DEPTH-1:0]        held,
  output logic [DEPTH*TS_W-1:0]   ts_flat,
  output logic [CELL_W-1:0]       rd_cell,
  output logic [TS_W-1:0]         rd_ts
);

  logic [CELL_W-1:0] cell_arr [DEPTH];
  logic [TS_W-1:0]   ts_arr   [DEPTH];

  for (genvar d = 0; d < DEPTH; d++) begin : g_place
    logic              held_q;
    logic [CELL_W-1:0] cell_q;
    logic [TS_W-1:0]   ts_q;
    logic              fill;
    logic [CELL_W-1:0] cell_n;
    logic [TS_W-1:0]   ts_n;

    // Which lane, if any, writes this place in the current slot.
    always_comb begin
      fill   = 1'b0;
      cell_n = cell_q;
      ts_n   = ts_q;
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l] && (wr_slot[l*IDX_W +: IDX_W] == IDX_W'(d))) begin
          fill   = 1'b1;
          cell_n = wr_cell[l*CELL_W +: CELL_W];
          ts_n   = wr_ts[l*TS_W +: TS_W];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                                    held_q <= 1'b0;
      else if (fill)                              held_q <= 1'b1;
      else if (rd_en && (rd_slot == IDX_W'(d)))   held_q <= 1'b0;
    end

    // Payload storage carries no reset.
    always_ff @(posedge clk) begin
      if (fill) begin
        cell_q <= cell_n;
        ts_q   <= ts_n;
      end
    end

    assign held[d]                  = held_q;
    assign cell_arr[d]              = cell_q;
    assign ts_arr[d]                = ts_q;
    assign ts_flat[d*TS_W +: TS_W]  = ts_q;
  end

  assign rd_cell = cell_arr[rd_slot];
  assign rd_ts   = ts_arr[rd_slot];

endmodule

// File: rtl/reseq_pick.sv
module reseq_pick #(
  parameter int unsigned DEPTH       = 12,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned TS_W        = 6,
  parameter int unsigned RELEASE_DLY = 12
) (
  input  logic [TS_W-1:0]       now_i,
  input  logic [DEPTH-1:0]      held,
  input  logic [DEPTH*TS_W-1:0] ts_flat,
  output logic                  found,
  output logic [IDX_W-1:0]      slot
);

  localparam logic [TS_W-1:0] DLY = TS_W'(RELEASE_DLY);

  logic [TS_W-1:0]  age [DEPTH];
  logic [DEPTH-1:0] ripe;
  logic [TS_W-1:0]  best;

  for (genvar d = 0; d < DEPTH; d++) begin : g_age
    assign age[d]  = now_i - ts_flat[d*TS_W +: TS_W];
    assign ripe[d] = held[d] && (age[d] >= DLY);
  end

  // Oldest eligible place wins; strict compare keeps the lowest index on ties.
  always_comb begin
    found = 1'b0;
    slot  = '0;
    best  = '0;
    for (int d = 0; d < DEPTH; d++) begin
      if (ripe[d] && (!found || (age[d] > best))) begin
        found = 1'b1;
        slot  = IDX_W'(d);
        best  = age[d];
      end
    end
  end

endmodule

// File: rtl/reseq_mux.sv
module reseq_mux #(
  parameter int unsigned NUM_LAYERS  = 3,
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned CELL_W      = 16,
  parameter int unsigned TS_W        = 6,
  parameter int unsigned RELEASE_DLY = NUM_PORTS * NUM_LAYERS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LAYERS-1:0]        lane_valid,
  input  logic [NUM_LAYERS*CELL_W-1:0] lane_cell,
  input  logic [NUM_LAYERS*TS_W-1:0]   lane_ts,
  output logic                         out_valid,
  output logic [CELL_W-1:0]            out_cell,
  output logic [TS_W-1:0]              out_ts,
  output logic                         overflow
);

  localparam int unsigned DEPTH = NUM_PORTS * NUM_LAYERS;
  localparam int unsigned IDX_W = reseq_pkg::idx_bits(DEPTH);

  logic [TS_W-1:0]             now_q;
  logic [DEPTH-1:0]            occ;
  logic [DEPTH*TS_W-1:0]       ts_flat;
  logic [NUM_LAYERS-1:0]       grant;
  logic [NUM_LAYERS*IDX_W-1:0] wr_slot;
  logic                        drop;
  logic                        pick_found;
  logic [IDX_W-1:0]            pick_slot;
  logic [CELL_W-1:0]           rd_cell;
  logic [TS_W-1:0]             rd_ts;

  reseq_slot_clock #(.TS_W(TS_W)) u_clock (
    .clk   (clk),
    .rst   (rst),
    .now_o (now_q)
  );

  reseq_alloc #(.LANES(NUM_LAYERS), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
    .req    (lane_valid),
    .free_i (~occ),
    .grant  (grant),
    .slot_o (wr_slot),
    .drop   (drop)
  );

  reseq_store #(
    .LANES(NUM_LAYERS), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .CELL_W(CELL_W), .TS_W(TS_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (grant),
    .wr_slot (wr_slot),
    .wr_cell (lane_cell),
    .wr_ts   (lane_ts),
    .rd_en   (pick_found),
    .rd_slot (pick_slot),
    .held    (occ),
    .ts_flat (ts_flat),
    .rd_cell (rd_cell),
    .rd_ts   (rd_ts)
  );

  reseq_pick #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .TS_W(TS_W), .RELEASE_DLY(RELEASE_DLY)
  ) u_pick (
    .now_i   (now_q),
    .held    (occ),
    .ts_flat (ts_flat),
    .found   (pick_found),
    .slot    (pick_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      overflow  <= 1'b0;
      out_cell  <= '0;
      out_ts    <= '0;
    end else begin
      out_valid <= pick_found;
      overflow  <= drop;
      if (pick_found) begin
        out_cell <= rd_cell;
        out_ts   <= rd_ts;
      end
    end
  end

endmodule

// File: rtl/reseq_mux_chk.sv
module reseq_mux_chk #(
  parameter int unsigned LANES       = 3,
  parameter int unsigned DEPTH       = 12,
  parameter int unsigned TS_W        = 6,
  parameter int unsigned RELEASE_DLY = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            overflow,
  input logic [TS_W-1:0] out_ts,
  input logic [TS_W-1:0] now_q,
  input logic [DEPTH-1:0] occ
);

  localparam logic [TS_W-1:0] DLY = TS_W'(RELEASE_DLY);

  // R1: first slot after reset is quiet.
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !overflow));

  // R2: an emitted cell had aged at least the release delay when chosen.
  a_r2_aged_enough: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (TS_W'($past(now_q) - out_ts) >= DLY));

  // R4: an empty buffer produces no cell in the next slot.
  a_r4_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|occ) |=> !out_valid);

  // R7: a drop requires fewer free places than lanes.
  a_r7_drop_needs_space_short: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past($countones(occ)) > (DEPTH - LANES)));

  // R8: every emitted cell came out of a held place.
  a_r8_from_buffer: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(|occ));

endmodule

bind reseq_mux reseq_mux_chk #(
  .LANES(NUM_LAYERS), .DEPTH(DEPTH), .TS_W(TS_W), .RELEASE_DLY(RELEASE_DLY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .overflow  (overflow),
  .out_ts    (out_ts),
  .now_q     (now_q),
  .occ       (occ)
);

// File: tb/tb_reseq_mux.sv
`timescale 1ns/1ps
module tb_reseq_mux;

  localparam int LANES  = 3;
  localparam int PORTS  = 4;
  localparam int CELL_W = 16;
  localparam int TS_W   = 6;
  localparam int DLY    = PORTS * LANES;
  localparam int DEPTH  = PORTS * LANES;
  localparam int TMOD   = 1 << TS_W;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [LANES-1:0]        lane_valid = '0;
  logic [LANES*CELL_W-1:0] lane_cell = '0;
  logic [LANES*TS_W-1:0]   lane_ts = '0;
  logic                    out_valid;
  logic [CELL_W-1:0]       out_cell;
  logic [TS_W-1:0]         out_ts;
  logic                    overflow;

  reseq_mux #(
    .NUM_LAYERS(LANES), .NUM_PORTS(PORTS), .CELL_W(CELL_W),
    .TS_W(TS_W), .RELEASE_DLY(DLY)
  ) dut (
    .clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_cell(lane_cell),
    .lane_ts(lane_ts), .out_valid(out_valid), .out_cell(out_cell),
    .out_ts(out_ts), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  // Reference state built from the requirements.
  bit                m_held [DEPTH];
  int                m_ts   [DEPTH];
  logic [CELL_W-1:0] m_cell [DEPTH];
  int                m_now = 0;
  bit                exp_valid = 1'b0;
  bit                exp_ovf = 1'b0;
  logic [CELL_W-1:0] exp_cell = '0;
  int                exp_ts = 0;

  bit                v_in [LANES];
  logic [CELL_W-1:0] c_in [LANES];
  int                t_in [LANES];
  int                seq = 0;
  int                emitted = 0;
  int                drop_seen = 0;

  function automatic int wrapm(input int x);
    return ((x % TMOD) + TMOD) % TMOD;
  endfunction

  function automatic logic [CELL_W-1:0] next_cell();
    seq++;
    return CELL_W'(seq) & 16'h7FFF;
  endfunction

  task automatic model_step(input bit rstv);
    int sel;
    int best;
    bit dropped;
    if (rstv) begin
      for (int d = 0; d < DEPTH; d++) m_held[d] = 1'b0;
      m_now = 0;
      exp_valid = 1'b0;
      exp_ovf = 1'b0;
      return;
    end
    sel = -1;
    best = -1;
    for (int d = 0; d < DEPTH; d++) begin
      int age;
      age = wrapm(m_now - m_ts[d]);
      if (m_held[d] && age >= DLY && age > best) begin
        sel = d;
        best = age;
      end
    end
    exp_valid = (sel >= 0);
    if (sel >= 0) begin
      exp_cell = m_cell[sel];
      exp_ts = m_ts[sel];
    end
    dropped = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (v_in[l]) begin
        int place;
        place = -1;
        for (int d = DEPTH - 1; d >= 0; d--) if (!m_held[d]) place = d;
        if (place >= 0) begin
          m_held[place] = 1'b1;
          m_ts[place] = t_in[l];
          m_cell[place] = c_in[l];
        end else begin
          dropped = 1'b1;
        end
      end
    end
    if (sel >= 0) m_held[sel] = 1'b0;
    exp_ovf = dropped;
    m_now = wrapm(m_now + 1);
  endtask

  task automatic verify();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", cur_tag, out_valid, exp_valid);
    end
    if (exp_valid && out_valid === 1'b1) begin
      checks++;
      if (out_cell !== exp_cell || int'(out_ts) != exp_ts) begin
        errors++;
        $display("FAIL R8 cell/ts actual=%h/%0d expected=%h/%0d (%s)",
                 out_cell, out_ts, exp_cell, exp_ts, cur_tag);
      end
    end
    checks++;
    if (overflow !== exp_ovf) begin
      errors++;
      $display("FAIL R7 overflow actual=%0b expected=%0b", overflow, exp_ovf);
    end
    if (out_valid === 1'b1) begin
      emitted++;
      if (out_cell[CELL_W-1:8] == 8'hEE) drop_seen++;
    end
  endtask

  task automatic tick(input bit rstv);
    verify();
    rst = rstv;
    for (int l = 0; l < LANES; l++) begin
      lane_valid[l] = v_in[l];
      lane_cell[l*CELL_W +: CELL_W] = c_in[l];
      lane_ts[l*TS_W +: TS_W] = TS_W'(t_in[l]);
    end
    model_step(rstv);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) v_in[l] = 1'b0;
  endtask

  task automatic put(input int l, input int off, input logic [CELL_W-1:0] c);
    v_in[l] = 1'b1;
    t_in[l] = wrapm(m_now - off);
    c_in[l] = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < LANES; l++) begin
      v_in[l] = 1'b0; c_in[l] = '0; t_in[l] = 0;
    end
    for (int d = 0; d < DEPTH; d++) begin
      m_held[d] = 1'b0; m_ts[d] = 0; m_cell[d] = '0;
    end
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    model_step(1'b1);

    // R1: held reset, then quiet idle slots
    cur_tag = "R1";
    tick(1'b1);
    tick(1'b1);
    idle(6);

    // R2: single cell released exactly at the delay boundary
    cur_tag = "R2";
    put(0, 0, next_cell());
    tick(1'b0);
    idle(20);
    put(1, DLY - 1, next_cell());
    tick(1'b0);
    put(2, DLY + 3, next_cell());
    tick(1'b0);
    idle(6);

    // R3: shuffled offsets across lanes and adjacent slots
    cur_tag = "R3";
    put(0, 1, next_cell());
    put(1, 9, next_cell());
    put(2, 5, next_cell());
    tick(1'b0);
    put(0, 3, next_cell());
    put(2, 8, next_cell());
    tick(1'b0);
    put(1, 2, next_cell());
    put(2, 2, next_cell());
    tick(1'b0);
    idle(30);

    // R4: nothing buffered, nothing emitted
    cur_tag = "R4";
    idle(10);

    // R5: traffic across the counter wrap
    cur_tag = "R5";
    while (m_now != TMOD - 5) tick(1'b0);
    for (int i = 0; i < 10; i++) begin
      for (int l = 0; l < LANES; l++)
        if ($urandom_range(0, 1) == 1) put(l, $urandom_range(0, 15), next_cell());
      tick(1'b0);
    end
    idle(35);

    // R6 / R7: full-rate burst, capacity and drop
    cur_tag = "R6";
    emitted = 0;
    drop_seen = 0;
    for (int i = 0; i < DEPTH / LANES; i++) begin
      for (int l = 0; l < LANES; l++) put(l, 0, next_cell());
      tick(1'b0);
    end
    for (int l = 0; l < LANES; l++) put(l, 0, 16'hEE00 | CELL_W'(l));
    tick(1'b0);
    idle(45);
    checks++;
    if (emitted != DEPTH) begin
      errors++;
      $display("FAIL R6 cells emitted after burst actual=%0d expected=%0d", emitted, DEPTH);
    end
    checks++;
    if (drop_seen != 0) begin
      errors++;
      $display("FAIL R7 dropped cells seen actual=%0d expected=0", drop_seen);
    end

    // R1: reset while occupied empties the buffer
    cur_tag = "R1";
    for (int l = 0; l < LANES; l++) put(l, 0, next_cell());
    tick(1'b0);
    for (int l = 0; l < LANES; l++) put(l, DLY, next_cell());
    tick(1'b0);
    tick(1'b1);
    emitted = 0;
    idle(30);
    checks++;
    if (emitted != 0) begin
      errors++;
      $display("FAIL R1 cells after reset actual=%0d expected=0", emitted);
    end

    // R3: seeded random stream
    cur_tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      for (int l = 0; l < LANES; l++)
        if ($urandom_range(0, 3) == 0) put(l, $urandom_range(0, 15), next_cell());
      tick(1'b0);
    end
    idle(40);
    verify();

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule